// File: doc/BRIEF.md
# System Management Interrupt Handshake Controller

This block controls entry into and exit from a system management mode over a shared, open-drain-style, active-low interrupt pin. An external agent pulls the pin low to request the mode. The block samples the pin through one of two paths. The direct path is for a request that is synchronous to the clock. The registered path is for a request that may arrive asynchronously. Once it accepts a request, the block takes ownership of the pin and holds it low for as long as the mode lasts.

A resume strobe ends the mode. On a hardware-entered mode, the block then drives the pin high for one clock and releases it. The block does not re-arm until its selected sampling path has seen the pin high again, so only one request is active at a time.

Software can also enter the mode through a strobe. That entry leaves the pin alone and raises a flag. While the mode is active, non-maskable interrupts are either forwarded at once or held back. When held back, one occurrence is kept and delivered after exit.

Top module: `smi_handshake`

## Requirements
- R1: With `cfg_async`=0, a low level on the pin that is sampled at one rising edge puts the block into hardware mode at the next rising edge: `in_mode`=1, `pin_oe`=1, `pin_drv`=0. A single clock of low is enough.
- R2: With `cfg_async`=1, the pin must be sampled low at two consecutive edges, and hardware mode starts at the third edge after the first low sample. A low lasting one clock is never accepted.
- R3: Throughout hardware mode the pin is driven low (`pin_oe`=1, `pin_drv`=0), and the drive never goes straight from low to released.
- R4: A `resume` strobe in hardware mode clears `in_mode` at the next edge and drives the pin high (`pin_oe`=1, `pin_drv`=1) for exactly that one clock. `pin_oe` is 0 in the clock after.
- R5: After an exit, a new pin request is not accepted until the selected sampling path has seen the pin high while idle. A pin held low through exit causes no re-entry until it has gone high.
- R6: A `sw_entry` strobe while idle with `cfg_smi_en`=1 enters the mode at the next edge with `in_mode`=1 and `sw_flag`=1. In this mode `pin_oe` stays 0, pin requests are ignored, and `resume` returns the block to idle without driving the pin.
- R7: Pin requests are ignored when `cfg_smi_en`=0 or `cfg_region_open`=1. `sw_entry` is ignored when `cfg_smi_en`=0.
- R8: With `cfg_nmi_en`=0, an `nmi_in` pulse during the mode is not forwarded on `nmi_fwd`; it sets `nmi_pending` at the next edge. Any number of such pulses yields exactly one `nmi_fwd` cycle, in the first clock with `in_mode`=0, after which `nmi_pending` clears.
- R9: Outside the mode, or in the mode with `cfg_nmi_en`=1, `nmi_fwd` follows `nmi_in` in the same cycle.
- R10: While `rst_n`=0 and after reset: `in_mode`=0, `sw_flag`=0, `nmi_pending`=0 and `pin_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smi_pin_in | input | 1 | Sampled level of the shared interrupt pin (low = request) |
| cfg_async | input | 1 | 1 selects the two-stage synchronised sampling path |
| cfg_smi_en | input | 1 | Enables pin requests and software entry |
| cfg_region_open | input | 1 | 1 opens the mode's memory to normal operation; pin requests are ignored |
| cfg_nmi_en | input | 1 | 1 lets NMIs through during the mode |
| resume | input | 1 | One-clock strobe that ends the mode |
| sw_entry | input | 1 | One-clock strobe for software-initiated entry |
| nmi_in | input | 1 | Non-maskable interrupt event |
| pin_drv | output | 1 | Value driven onto the pin when enabled |
| pin_oe | output | 1 | Pin output enable |
| in_mode | output | 1 | Mode active |
| sw_flag | output | 1 | Current mode was entered by software |
| nmi_pending | output | 1 | One NMI held back for delivery after exit |
| nmi_fwd | output | 1 | NMI forwarded to the core |

## Verification
The in-design properties watch the pin drive on every cycle. They confirm that low drive is never released directly, that the high pulse lasts one clock, and that software mode never drives the pin. They also confirm that gating blocks hardware entry, that NMIs are suppressed in masked mode, and that a held-back NMI is delivered as soon as the mode ends. The bench scenarios cover what needs a history to judge: the exact entry latency of each sampling path across low-pulse lengths of one to four clocks, refusal of a one-clock low on the synchronised path, the re-arm rule with the pin held low through exit, and the collapse of several masked NMIs into one delivery.

// File: rtl/smi_handshake.sv
module smi_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic smi_pin_in,
  input  logic cfg_async,
  input  logic cfg_smi_en,
  input  logic cfg_region_open,
  input  logic cfg_nmi_en,
  input  logic resume,
  input  logic sw_entry,
  input  logic nmi_in,
  output logic pin_drv,
  output logic pin_oe,
  output logic in_mode,
  output logic sw_flag,
  output logic nmi_pending,
  output logic nmi_fwd
);

  typedef enum logic [1:0] {ST_IDLE, ST_HW, ST_SW, ST_REL} mode_t;

  mode_t st;
  logic  smp1, smp2, smp3;
  logic  armed;
  logic  nmi_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp1 <= 1'b0;
      smp2 <= 1'b0;
      smp3 <= 1'b0;
    end else begin
      smp1 <= ~smi_pin_in;
      smp2 <= smp1;
      smp3 <= smp2;
    end
  end

  wire path_low  = cfg_async ? (smp2 & smp3) : smp1;
  wire path_high = cfg_async ? ~smp2 : ~smp1;
  wire idle      = (st == ST_IDLE);
  wire hw_take   = idle & armed & cfg_smi_en & ~cfg_region_open & path_low;
  wire sw_take   = idle & cfg_smi_en & sw_entry & ~hw_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      armed <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (hw_take) st <= ST_HW;
                 else if (sw_take) st <= ST_SW;
        ST_HW:   if (resume) st <= ST_REL;
        ST_SW:   if (resume) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
      if (hw_take)
        armed <= 1'b0;
      else if (idle && path_high)
        armed <= 1'b1;
    end
  end

  assign pin_oe  = (st == ST_HW) | (st == ST_REL);
  assign pin_drv = (st == ST_REL);
  assign in_mode = (st == ST_HW) | (st == ST_SW);
  assign sw_flag = (st == ST_SW);

  wire nmi_open = ~in_mode | cfg_nmi_en;

  always_ff @(posedge clk) begin
    if (!rst_n)
      nmi_hold <= 1'b0;
    else if (nmi_open)
      nmi_hold <= 1'b0;
    else if (nmi_in)
      nmi_hold <= 1'b1;
  end

  assign nmi_pending = nmi_hold;
  assign nmi_fwd     = nmi_open & (nmi_in | nmi_hold);

  assert_low_not_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && !pin_drv) |=> pin_oe);

  assert_high_one_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && pin_drv) |=> !pin_oe);

  assert_no_reentry_after_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && pin_drv) |=> !in_mode);

  assert_sw_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_flag |-> !pin_oe);

  assert_gated_no_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_mode && !pin_oe && (!cfg_smi_en || cfg_region_open)) |=> !(pin_oe && !pin_drv));

  assert_nmi_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode && !cfg_nmi_en) |-> !nmi_fwd);

  assert_nmi_delivered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pending && !in_mode) |-> nmi_fwd);

  assert_nmi_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_in && (!in_mode || cfg_nmi_en)) |-> nmi_fwd);

endmodule

// File: tb/test_smi_handshake.sv
module test_smi_handshake;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_low = 1'b0;
  logic cfg_async = 1'b0, cfg_smi_en = 1'b1, cfg_region_open = 1'b0, cfg_nmi_en = 1'b0;
  logic resume = 1'b0, sw_entry = 1'b0, nmi_in = 1'b0;
  logic pin_drv, pin_oe, in_mode, sw_flag, nmi_pending, nmi_fwd;
  int checks = 0;
  int fails = 0;

  wire pin = ext_low ? 1'b0 : (pin_oe ? pin_drv : 1'b1);

  always #4 clk = ~clk;

  smi_handshake i_smi_handshake (
    .clk(clk), .rst_n(rst_n), .smi_pin_in(pin), .cfg_async(cfg_async),
    .cfg_smi_en(cfg_smi_en), .cfg_region_open(cfg_region_open), .cfg_nmi_en(cfg_nmi_en),
    .resume(resume), .sw_entry(sw_entry), .nmi_in(nmi_in),
    .pin_drv(pin_drv), .pin_oe(pin_oe), .in_mode(in_mode), .sw_flag(sw_flag),
    .nmi_pending(nmi_pending), .nmi_fwd(nmi_fwd));

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic do_resume_hw();
    resume = 1'b1;
    step();
    resume = 1'b0;
    check("R4", "in_mode after resume", in_mode, 1'b0);
    check("R4", "oe in high pulse", pin_oe, 1'b1);
    check("R4", "drv in high pulse", pin_drv, 1'b1);
    step();
    check("R4", "released after pulse", pin_oe, 1'b0);
  endtask

  task automatic idle_wait(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    idle_wait(3);
    check("R10", "in_mode in reset", in_mode, 1'b0);
    check("R10", "sw_flag in reset", sw_flag, 1'b0);
    check("R10", "nmi_pending in reset", nmi_pending, 1'b0);
    check("R10", "pin_oe in reset", pin_oe, 1'b0);
    rst_n = 1'b1;
    idle_wait(4);
    check("R10", "in_mode after reset", in_mode, 1'b0);

    // R1 and R2 sweep over both sampling paths and low lengths
    for (int a = 0; a < 2; a++) begin
      for (int d = 1; d <= 4; d++) begin
        int exp_edge;
        string req;
        cfg_async = a[0];
        req = a ? "R2" : "R1";
        exp_edge = a ? ((d >= 2) ? 4 : 0) : 2;
        ext_low = 1'b1;
        for (int c = 1; c <= 6; c++) begin
          step();
          if (c == d) ext_low = 1'b0;
          check(req, "in_mode vs entry edge", in_mode, (exp_edge > 0) && (c >= exp_edge));
          if (exp_edge > 0 && c >= exp_edge) begin
            check("R3", "oe during mode", pin_oe, 1'b1);
            check("R3", "drv low during mode", pin_drv, 1'b0);
          end
        end
        if (exp_edge > 0) do_resume_hw();
        idle_wait(5);
      end
    end

    // R5: pin held low through exit
    cfg_async = 1'b0;
    ext_low = 1'b1;
    idle_wait(2);
    check("R5", "entered", in_mode, 1'b1);
    resume = 1'b1;
    step();
    resume = 1'b0;
    for (int c = 0; c < 6; c++) begin
      step();
      check("R5", "no re-entry while held low", in_mode, 1'b0);
    end
    ext_low = 1'b0;
    idle_wait(3);
    check("R5", "still idle after release", in_mode, 1'b0);
    ext_low = 1'b1;
    idle_wait(2);
    check("R5", "re-entry after high phase", in_mode, 1'b1);
    ext_low = 1'b0;
    do_resume_hw();
    idle_wait(4);

    // R7: gating
    cfg_smi_en = 1'b0;
    ext_low = 1'b1;
    for (int c = 0; c < 4; c++) begin
      step();
      check("R7", "ignored with enable off", in_mode, 1'b0);
    end
    sw_entry = 1'b1;
    step();
    sw_entry = 1'b0;
    check("R7", "sw entry ignored with enable off", in_mode, 1'b0);
    cfg_smi_en = 1'b1;
    cfg_region_open = 1'b1;
    for (int c = 0; c < 4; c++) begin
      step();
      check("R7", "ignored with region open", in_mode, 1'b0);
    end
    ext_low = 1'b0;
    idle_wait(4);
    cfg_region_open = 1'b0;
    idle_wait(2);
    check("R7", "no entry once pin high", in_mode, 1'b0);

    // R6: software entry
    sw_entry = 1'b1;
    step();
    sw_entry = 1'b0;
    check("R6", "sw in_mode", in_mode, 1'b1);
    check("R6", "sw_flag", sw_flag, 1'b1);
    check("R6", "no drive in sw mode", pin_oe, 1'b0);
    ext_low = 1'b1;
    for (int c = 0; c < 4; c++) begin
      step();
      check("R6", "pin request ignored in sw mode", pin_oe, 1'b0);
      check("R6", "sw_flag kept", sw_flag, 1'b1);
    end
    ext_low = 1'b0;
    idle_wait(4);

    // R8: masked NMIs during mode
    cfg_nmi_en = 1'b0;
    for (int k = 0; k < 2; k++) begin
      nmi_in = 1'b1;
      #1;
      check("R8", "masked nmi not forwarded", nmi_fwd, 1'b0);
      step();
      nmi_in = 1'b0;
      check("R8", "nmi latched", nmi_pending, 1'b1);
      step();
    end
    // R9: unmasked NMI in mode
    cfg_nmi_en = 1'b1;
    #1;
    check("R9", "held nmi delivered when unmasked", nmi_fwd, 1'b1);
    step();
    check("R9", "pending cleared", nmi_pending, 1'b0);
    nmi_in = 1'b1;
    #1;
    check("R9", "nmi passes in mode", nmi_fwd, 1'b1);
    step();
    nmi_in = 1'b0;
    cfg_nmi_en = 1'b0;
    nmi_in = 1'b1;
    step();
    nmi_in = 1'b0;
    check("R8", "latched again", nmi_pending, 1'b1);
    resume = 1'b1;
    step();
    resume = 1'b0;
    check("R6", "sw exit clears mode", in_mode, 1'b0);
    check("R6", "sw exit no drive", pin_oe, 1'b0);
    check("R8", "delivered after exit", nmi_fwd, 1'b1);
    step();
    check("R8", "single delivery", nmi_fwd, 1'b0);
    check("R8", "pending cleared after exit", nmi_pending, 1'b0);
    nmi_in = 1'b1;
    #1;
    check("R9", "nmi passes outside mode", nmi_fwd, 1'b1);
    step();
    nmi_in = 1'b0;

    // R8 with hardware mode, NMI delivered during the high pulse
    ext_low = 1'b1;
    idle_wait(2);
    ext_low = 1'b0;
    check("R1", "hw entry", in_mode, 1'b1);
    nmi_in = 1'b1;
    step();
    nmi_in = 1'b0;
    resume = 1'b1;
    step();
    resume = 1'b0;
    check("R8", "delivered in high pulse", nmi_fwd, 1'b1);
    check("R4", "high pulse", pin_drv, 1'b1);
    step();
    check("R8", "no second delivery", nmi_fwd, 1'b0);
    idle_wait(3);
    finish_run();
  end
endmodule